// File: doc/BRIEF.md
# Serial-loaded control register bank

This block is the write side of a small control register bank that is loaded over a three-wire serial link: a shift clock, a data line and a load strobe. The controller shifts a 32-bit word into the block, most significant bit first. It then raises the load strobe. On that rising edge the word is stored in the register named by its three lowest bits. The block samples all three serial lines with its own system clock. It finds their rising edges there, so it expects lines that are already synchronous to that clock or sampled well below its rate.

The bank holds six registers. Each one stores the 29 upper bits of the word written to it, and all six are always visible on one flat parallel output. In register 1, the 12-bit modulus field is double buffered: a write to register 1 only arms a pending copy. The value on the output changes when register 0 is next written, so a new integer and fraction setting and the new modulus take effect together. A chip-enable input is passed on to enable the downstream logic. The register contents stay as they are when chip enable is low.

Top module: `serial_cfg_bank`

## Requirements
- R1: After reset, every register output bit and the pending modulus copy are zero.
- R2: On each clock where the shift clock is sampled high after being low, the sampled data bit enters the shift register at bit 0 and older bits move up by one, so the first bit sent ends in bit 31.
- R3: On a clock where the load strobe is sampled high after being low, and the shifted word's bits [2:0] hold a value from 0 to 5, that register takes the word's bits [31:3]. The new value is visible on the output after that clock edge.
- R4: A load whose address bits [2:0] are 6 or 7 changes no register output.
- R5: The address bits are not stored; register k is presented as 29 bits at `cfg_o[k*29 +: 29]`, holding word bits [31:3].
- R6: A write to register 1 updates its non-modulus bits at once. The modulus field, word bits [14:3] (output bits [11:0] of register 1), keeps its previous value and the new value is held as pending.
- R7: A write to register 0 moves the pending modulus into register 1's modulus field on the same clock edge that updates register 0.
- R8: While the load strobe stays high, further shifting commits nothing; only its next rising edge stores the word.
- R9: `core_en` follows `ce`; a low `ce` leaves the register contents unchanged, and loads made while `ce` is low still take effect.
- R10: Only the last 32 bits shifted before a load count; earlier bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, most significant bit first |
| sload | input | 1 | Load strobe, commits on its rising edge |
| ce | input | 1 | Chip enable |
| core_en | output | 1 | Enable passed to the downstream logic |
| cfg_o | output | 174 | Six 29-bit register values, register 0 in the low bits |

## Verification
The bench builds the block with its default parameters: six registers, 32-bit words, three address bits, and the modulus at word bits 14:3 of register 1 with register 0 as its commit trigger. With these values the two unused address codes, 6 and 7, can be exercised. The bench also reaches the split between register 1's buffered field and its other bits, and the order in which a register 1 write and a register 0 write bring a modulus into effect.

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 6,
  parameter int MOD_REG  = 1,
  parameter int LOAD_REG = 0,
  parameter int MOD_LO   = 3,
  parameter int MOD_HI   = 14
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               sclk,
  input  logic                               sdata,
  input  logic                               sload,
  input  logic                               ce,
  output logic                               core_en,
  output logic [NUM_REGS*(WORD_W-ADDR_W)-1:0] cfg_o
);
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int MOD_W  = MOD_HI - MOD_LO + 1;
  localparam int M_OFS  = MOD_LO - ADDR_W;
  localparam logic [DATA_W-1:0] MOD_MASK = DATA_W'({MOD_W{1'b1}}) << M_OFS;

  logic [WORD_W-1:0] shift_q;
  logic              sclk_q, sload_q;
  logic [MOD_W-1:0]  mod_pend_q, mod_live_q;

  wire               shift_step = sclk & ~sclk_q;
  wire               commit     = sload & ~sload_q;
  wire [ADDR_W-1:0]  wr_addr    = shift_q[ADDR_W-1:0];
  wire [DATA_W-1:0]  wr_data    = shift_q[WORD_W-1:ADDR_W];

  assign core_en = ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      sload_q <= sload;
      if (shift_step) shift_q <= {shift_q[WORD_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_pend_q <= '0;
      mod_live_q <= '0;
    end else if (commit) begin
      if (wr_addr == ADDR_W'(MOD_REG))  mod_pend_q <= wr_data[M_OFS +: MOD_W];
      if (wr_addr == ADDR_W'(LOAD_REG)) mod_live_q <= mod_pend_q;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  word_q <= '0;
      else if (commit && wr_addr == ADDR_W'(i))    word_q <= wr_data;
    end

    if (i == MOD_REG) begin : g_buf
      assign cfg_o[i*DATA_W +: DATA_W] =
        (word_q & ~MOD_MASK) | (DATA_W'(mod_live_q) << M_OFS);
    end else begin : g_dir
      assign cfg_o[i*DATA_W +: DATA_W] = word_q;
    end
  end
endmodule

// File: rtl/serial_cfg_bank_chk.sv
module serial_cfg_bank_chk #(
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 6,
  parameter int MOD_REG  = 1,
  parameter int LOAD_REG = 0,
  parameter int MOD_LO   = 3,
  parameter int MOD_HI   = 14
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                sclk,
  input logic                                sdata,
  input logic                                sload,
  input logic [WORD_W-1:0]                   shift_q,
  input logic [MOD_HI-MOD_LO:0]              mod_pend_q,
  input logic [NUM_REGS*(WORD_W-ADDR_W)-1:0] cfg_o
);
  localparam int DATA_W  = WORD_W - ADDR_W;
  localparam int MOD_W   = MOD_HI - MOD_LO + 1;
  localparam int MOD_POS = MOD_REG*DATA_W + MOD_LO - ADDR_W;

  logic sclk_seen, sload_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_seen  <= 1'b0;
      sload_seen <= 1'b0;
    end else begin
      sclk_seen  <= sclk;
      sload_seen <= sload;
    end
  end

  wire              c_step = sclk & ~sclk_seen;
  wire              c_load = sload & ~sload_seen;
  wire [ADDR_W-1:0] wa     = shift_q[ADDR_W-1:0];
  wire [MOD_W-1:0]  live   = cfg_o[MOD_POS +: MOD_W];

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_step |=> shift_q[0] == $past(sdata));

  p_store_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_load && wa < NUM_REGS && wa != MOD_REG |=>
      cfg_o[$past(wa)*DATA_W +: DATA_W] == $past(shift_q[WORD_W-1:ADDR_W]));

  p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    c_load && wa >= NUM_REGS |=> $stable(cfg_o));

  p_mod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_load && wa == MOD_REG && wa != LOAD_REG |=> $stable(live));

  p_mod_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_load && wa == LOAD_REG |=> live == $past(mod_pend_q));

  p_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !c_load |=> $stable(cfg_o));
endmodule

bind serial_cfg_bank serial_cfg_bank_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .MOD_REG(MOD_REG),
  .LOAD_REG(LOAD_REG), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
  .shift_q(shift_q), .mod_pend_q(mod_pend_q), .cfg_o(cfg_o)
);

// File: tb/test_serial_cfg_bank.sv
module test_serial_cfg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 29;
  localparam int NR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0, ce = 1'b1;
  logic core_en;
  logic [NR*DW-1:0] cfg_o;

  int checks = 0;
  int errors = 0;

  serial_cfg_bank i_serial_cfg_bank (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
    .ce(ce), .core_en(core_en), .cfg_o(cfg_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: a bit queue and a word array
  bit              bits_q[$];
  logic [DW-1:0]   m_reg [NR];
  logic [11:0]     m_pend, m_live;
  logic            m_sclk_prev, m_load_prev;

  function automatic logic [NR*DW-1:0] model_out();
    logic [NR*DW-1:0] r;
    for (int k = 0; k < NR; k++) begin
      logic [DW-1:0] w;
      w = m_reg[k];
      if (k == 1) w[11:0] = m_live;
      r[k*DW +: DW] = w;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bits_q.delete();
      for (int k = 0; k < NR; k++) m_reg[k] = '0;
      m_pend = '0; m_live = '0;
      m_sclk_prev = 1'b0; m_load_prev = 1'b0;
    end else begin
      logic [31:0] word;
      word = '0;
      for (int k = 0; k < bits_q.size(); k++) word[bits_q.size()-1-k] = bits_q[k];
      if (sload && !m_load_prev) begin
        int a;
        a = int'(word[2:0]);
        if (a < NR) begin
          if (a == 1) m_pend = word[14:3];
          if (a == 0) m_live = m_pend;
          m_reg[a] = word[31:3];
        end
      end
      if (sclk && !m_sclk_prev) begin
        bits_q.push_back(sdata);
        if (bits_q.size() > 32) void'(bits_q.pop_front());
      end
      m_sclk_prev = sclk;
      m_load_prev = sload;
    end
  end

  task automatic check(string tag, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R3 per-cycle comparison against the reference, R9 enable path
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 model", 192'(cfg_o), 192'(model_out()));
      check("R9 core_en", 192'(core_en), 192'(ce));
    end
  end

  function automatic logic [DW-1:0] reg_of(int k);
    return cfg_o[k*DW +: DW];
  endfunction

  task automatic shift_bit(logic b);
    @(negedge clk); sdata = b; sclk = 1'b0;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic shift_word(logic [31:0] w);
    for (int b = 31; b >= 0; b--) shift_bit(w[b]);
  endtask

  task automatic load_pulse();
    @(negedge clk); sload = 1'b1;
    @(negedge clk); sload = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_word(logic [31:0] w);
    shift_word(w);
    load_pulse();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NR*DW-1:0] snap;
    logic [31:0] w1a, w1b, w0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 192'(cfg_o), 192'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 192'(cfg_o), 192'(0));

    // R3 / R5: plain write to register 3
    write_word(32'hA5A5_5A5B);
    check("R3 reg3", 192'(reg_of(3)), 192'(29'(32'hA5A5_5A5B >> 3)));
    check("R5 reg2 untouched", 192'(reg_of(2)), 192'(0));

    // R2: bit order, first bit sent lands in bit 31
    write_word(32'h8000_0002);
    check("R2 msb first", 192'(reg_of(2)), 192'(29'h1000_0000));

    // R6: register 1 write, modulus field held
    w1a = 32'h1234_5679;
    write_word(w1a);
    check("R6 reg1 upper", 192'(reg_of(1) & ~29'hFFF), 192'((w1a >> 3) & ~32'hFFF));
    check("R6 mod held", 192'(reg_of(1) & 29'hFFF), 192'(0));

    // R7: register 0 write brings the pending modulus in
    w0 = 32'h0000_0100;
    write_word(w0);
    check("R7 reg0", 192'(reg_of(0)), 192'(w0 >> 3));
    check("R7 mod live", 192'(reg_of(1) & 29'hFFF), 192'((w1a >> 3) & 32'hFFF));

    // R6 again: second register 1 write keeps old modulus until reg0
    w1b = 32'hFEDC_BA99;
    write_word(w1b);
    check("R6 mod still old", 192'(reg_of(1) & 29'hFFF), 192'((w1a >> 3) & 32'hFFF));
    write_word(32'h0000_0002);
    check("R6 reg2 write no mod", 192'(reg_of(1) & 29'hFFF), 192'((w1a >> 3) & 32'hFFF));
    write_word(32'h0000_0008);
    check("R7 second commit", 192'(reg_of(1) & 29'hFFF), 192'((w1b >> 3) & 32'hFFF));

    // R4: addresses 6 and 7 ignored
    snap = cfg_o;
    write_word(32'hFFFF_FFFE);
    check("R4 addr6", 192'(cfg_o), 192'(snap));
    write_word(32'hFFFF_FFFF);
    check("R4 addr7", 192'(cfg_o), 192'(snap));

    // R8: load held high while shifting
    shift_word(32'h1111_1114);
    @(negedge clk); sload = 1'b1;
    @(negedge clk);
    check("R8 first commit", 192'(reg_of(4)), 192'(29'(32'h1111_1114 >> 3)));
    shift_word(32'h2222_2224);
    check("R8 no commit while high", 192'(reg_of(4)), 192'(29'(32'h1111_1114 >> 3)));
    @(negedge clk); sload = 1'b0;
    @(negedge clk);
    check("R8 no commit on fall", 192'(reg_of(4)), 192'(29'(32'h1111_1114 >> 3)));
    load_pulse();
    check("R8 next rise commits", 192'(reg_of(4)), 192'(29'(32'h2222_2224 >> 3)));

    // R10: extra leading bits dropped
    for (int k = 0; k < 9; k++) shift_bit(1'b1);
    write_word(32'h0F0F_0F0D);
    check("R10 last 32 bits", 192'(reg_of(5)), 192'(29'(32'h0F0F_0F0D >> 3)));

    // R9: chip enable low
    snap = cfg_o;
    @(negedge clk); ce = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 core_en low", 192'(core_en), 192'(0));
    check("R9 retained", 192'(cfg_o), 192'(snap));
    write_word(32'h3333_3333);
    check("R9 write while off", 192'(reg_of(3)), 192'(29'(32'h3333_3333 >> 3)));
    @(negedge clk); ce = 1'b1;
    @(negedge clk);
    check("R9 core_en high", 192'(core_en), 192'(1));

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule